// File: doc/BRIEF.md
# Two-Wire Bus START/STOP Condition Generator

This block is the bus-master part of a two-wire serial interface that creates the START and STOP conditions on the data line (SDA) and the clock line (SCL). Software controls it through a register-style status write. The write carries four bits: master, transmit, busy, and a strobe. An interface-enable input gates the block. A write with master, transmit and busy all set asks for a START. A write with master and transmit set and busy clear asks for a STOP.

Each condition is a fixed sequence. A setup interval is followed by the line change, and then a hold interval. The lengths are exact cycle counts, chosen by a standard/high-speed mode select that is sampled when the write is accepted. A bus-busy flag is set after a START and cleared after a STOP. It changes after its own delay, counted from the accepted write and not tied to any line edge. When a START completes, the block clears a 3-bit bit counter and gives a one-cycle hand-off pulse to the byte clocking logic. That logic steps the counter afterwards.

Both lines are open-drain. An output-enable of 1 pulls the line low, and 0 releases it high.

Top module: `bus_cond_gen`

## Requirements
- R1: A status write is acted on only while `ctl_en` is 1. A write made with `ctl_en` at 0 changes neither line, the busy flag nor `cond_done`.
- R2: START (write with master=1, transmit=1, busy=1): at the accepting edge both lines are released. After the setup interval, `sda_oe` goes to 1 while `scl_oe` stays 0. After the hold interval, `scl_oe` goes to 1. SDA then stays driven low.
- R3: STOP (write with master=1, transmit=1, busy=0): at the accepting edge `sda_oe` goes to 1 and `scl_oe` to 0. After the setup interval, `sda_oe` goes to 0 and both lines stay released through the hold interval.
- R4: With `fast_mode`=0 at the accepting edge, the SDA change comes 17 edges after the accepting edge and the end of the condition comes 37 edges after it (setup 17 + hold 20).
- R5: With `fast_mode`=1 at the accepting edge, the SDA change comes 7 edges after it and the end comes 17 edges after it (setup 7 + hold 10). A later change of `fast_mode` does not alter a condition in progress.
- R6: `bus_busy` becomes 1 exactly 12 edges (standard) or 6 edges (high-speed) after a START is accepted. It becomes 0 after the same delays for a STOP, and at no other time.
- R7: On the final edge of a START, `bit_cnt` becomes 0 and `byte_go` pulses for one cycle. Otherwise each cycle with `bit_step`=1 increments `bit_cnt`, wrapping from 7 to 0.
- R8: A write arriving while a condition is in progress is ignored. A write with master=0 or transmit=0 is ignored.
- R9: `cond_done` is high for exactly one cycle after the final edge of each START and each STOP.
- R10: While `rst_n` is 0 at a clock edge, both output-enables, `bus_busy`, `bit_cnt`, `cond_done` and `byte_go` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_en | input | 1 | Interface enable |
| fast_mode | input | 1 | 1 = high-speed interval set, 0 = standard |
| wr_stb | input | 1 | Status-write strobe, one cycle |
| wr_master | input | 1 | Master bit of the status write |
| wr_xmit | input | 1 | Transmit bit of the status write |
| wr_busy | input | 1 | Busy bit of the status write (1 = START, 0 = STOP) |
| bit_step | input | 1 | Advance request for the bit counter from byte clocking |
| sda_oe | output | 1 | SDA pull-down enable (1 = line low) |
| scl_oe | output | 1 | SCL pull-down enable (1 = line low) |
| bus_busy | output | 1 | Bus-busy flag |
| bit_cnt | output | 3 | Bit counter |
| byte_go | output | 1 | One-cycle hand-off to byte clocking after START |
| cond_done | output | 1 | One-cycle end-of-condition pulse |

## Verification
The assertions check on every cycle the properties that hold locally:
- `cond_done` never lasts two cycles.
- SDA only moves during a condition while SCL is released.
- The busy flag only moves when its own timer expires.
- A disabled, idle block stays idle.
- The counter reads zero with every hand-off pulse.

The exact cycle counts in both modes, the separation between the busy delay and the line edges, and the ignoring of late or malformed writes can only be shown by the bench's scenarios. Its behavioural model predicts each output edge by edge.

// File: rtl/bus_cond_pkg.sv
// Package: shared types and helpers for the two-wire condition generator.
// Assumes: nothing beyond IEEE 1800-2017.
package bus_cond_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    typedef enum logic {
        COND_START = 1'b0,
        COND_STOP  = 1'b1
    } cond_e;

    // Larger of two counts, used to size down-counters.
    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cond_decode.sv
// Module: cond_decode
// Turns a status write into a START or STOP request.
// Assumes: wr_stb is a single-cycle strobe. seq_busy is high while the
// sequencer runs, and requests made then are dropped.
module cond_decode (
    input  logic ctl_en,
    input  logic wr_stb,
    input  logic wr_master,
    input  logic wr_xmit,
    input  logic wr_busy,
    input  logic seq_busy,
    output logic go_start,
    output logic go_stop
);

    logic accept;

    // Qualify the write: enabled, idle, master transmitter.
    always_comb begin
        accept   = wr_stb && ctl_en && !seq_busy && wr_master && wr_xmit;
        go_start = accept && wr_busy;
        go_stop  = accept && !wr_busy;
    end

endmodule

// File: rtl/cond_seq.sv
// Module: cond_seq
// Sequences SDA and SCL for one START or STOP: setup interval, SDA change,
// hold interval. The interval set is latched from fast_mode at acceptance.
// Assumes: go_start/go_stop arrive only while idle, and every interval >= 1.
module cond_seq
    import bus_cond_pkg::*;
#(
    parameter int unsigned SU_STD  = 17,
    parameter int unsigned HD_STD  = 20,
    parameter int unsigned SU_FAST = 7,
    parameter int unsigned HD_FAST = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_start,
    input  logic go_stop,
    input  logic fast_mode,
    output logic sda_oe,
    output logic scl_oe,
    output logic active,
    output logic start_fin,
    output logic done,
    output logic start_done
);

    localparam int unsigned MAXC  = max_of(max_of(SU_STD, HD_STD), max_of(SU_FAST, HD_FAST));
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] SU_S = CNT_W'(SU_STD - 1);
    localparam logic [CNT_W-1:0] HD_S = CNT_W'(HD_STD - 1);
    localparam logic [CNT_W-1:0] SU_F = CNT_W'(SU_FAST - 1);
    localparam logic [CNT_W-1:0] HD_F = CNT_W'(HD_FAST - 1);

    phase_e           ph_q;
    cond_e            kind_q;
    logic             fast_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    // Terminal count of the running interval.
    always_comb begin
        last_tick = (cnt_q == '0);
        active    = (ph_q != PH_IDLE);
        start_fin = (ph_q == PH_HOLD) && last_tick && (kind_q == COND_START);
    end

    // Phase, interval counter and line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= PH_IDLE;
            kind_q     <= COND_START;
            fast_q     <= 1'b0;
            cnt_q      <= '0;
            sda_oe     <= 1'b0;
            scl_oe     <= 1'b0;
            done       <= 1'b0;
            start_done <= 1'b0;
        end else begin
            done       <= 1'b0;
            start_done <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (go_start || go_stop) begin
                        ph_q   <= PH_SETUP;
                        kind_q <= go_start ? COND_START : COND_STOP;
                        fast_q <= fast_mode;
                        cnt_q  <= fast_mode ? SU_F : SU_S;
                        sda_oe <= go_stop;
                        scl_oe <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (last_tick) begin
                        ph_q   <= PH_HOLD;
                        cnt_q  <= fast_q ? HD_F : HD_S;
                        sda_oe <= (kind_q == COND_START);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last_tick) begin
                        ph_q <= PH_IDLE;
                        done <= 1'b1;
                        if (kind_q == COND_START) begin
                            scl_oe     <= 1'b1;
                            start_done <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && (sda_oe != $past(sda_oe))) |-> !scl_oe);

    // R3
    stop_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SETUP && kind_q == COND_STOP) |-> (sda_oe && !scl_oe));

endmodule

// File: rtl/busy_timer.sv
// Module: busy_timer
// Sets or clears the bus-busy flag a fixed delay after an accepted request,
// independently of the line sequencing.
// Assumes: every delay >= 1 and shorter than a full condition, so a new
// request never finds the timer pending.
module busy_timer
    import bus_cond_pkg::*;
#(
    parameter int unsigned BB_STD  = 12,
    parameter int unsigned BB_FAST = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_start,
    input  logic go_stop,
    input  logic fast_mode,
    output logic busy
);

    localparam int unsigned BW = $clog2(max_of(BB_STD, BB_FAST) + 1);
    localparam logic [BW-1:0] BB_S = BW'(BB_STD - 1);
    localparam logic [BW-1:0] BB_F = BW'(BB_FAST - 1);

    logic          pend_q;
    logic          tgt_q;
    logic [BW-1:0] cnt_q;
    logic          expire;

    // Timer reaches its last cycle.
    always_comb expire = pend_q && (cnt_q == '0);

    // Delay counter and flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            tgt_q  <= 1'b0;
            cnt_q  <= '0;
            busy   <= 1'b0;
        end else if (go_start || go_stop) begin
            pend_q <= 1'b1;
            tgt_q  <= go_start;
            cnt_q  <= fast_mode ? BB_F : BB_S;
        end else if (expire) begin
            pend_q <= 1'b0;
            busy   <= tgt_q;
        end else if (pend_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R6
    busy_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy != $past(busy)) |-> $past(expire));

endmodule

// File: rtl/bus_cond_gen.sv
// Module: bus_cond_gen (top)
// START/STOP condition generator for a two-wire bus master. It joins the
// write decode, the line sequencer, the busy timer and the 3-bit counter.
// Assumes: open-drain pads outside (oe=1 pulls low). All inputs are
// synchronous to clk.
module bus_cond_gen #(
    parameter int unsigned SU_STD  = 17,
    parameter int unsigned HD_STD  = 20,
    parameter int unsigned BB_STD  = 12,
    parameter int unsigned SU_FAST = 7,
    parameter int unsigned HD_FAST = 10,
    parameter int unsigned BB_FAST = 6,
    parameter int unsigned BIT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             fast_mode,
    input  logic             wr_stb,
    input  logic             wr_master,
    input  logic             wr_xmit,
    input  logic             wr_busy,
    input  logic             bit_step,
    output logic             sda_oe,
    output logic             scl_oe,
    output logic             bus_busy,
    output logic [BIT_W-1:0] bit_cnt,
    output logic             byte_go,
    output logic             cond_done
);

    logic go_start, go_stop, seq_active, start_fin;

    cond_decode u_dec (
        .ctl_en    (ctl_en),
        .wr_stb    (wr_stb),
        .wr_master (wr_master),
        .wr_xmit   (wr_xmit),
        .wr_busy   (wr_busy),
        .seq_busy  (seq_active),
        .go_start  (go_start),
        .go_stop   (go_stop)
    );

    cond_seq #(
        .SU_STD (SU_STD), .HD_STD (HD_STD),
        .SU_FAST(SU_FAST), .HD_FAST(HD_FAST)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_start   (go_start),
        .go_stop    (go_stop),
        .fast_mode  (fast_mode),
        .sda_oe     (sda_oe),
        .scl_oe     (scl_oe),
        .active     (seq_active),
        .start_fin  (start_fin),
        .done       (cond_done),
        .start_done (byte_go)
    );

    busy_timer #(
        .BB_STD(BB_STD), .BB_FAST(BB_FAST)
    ) u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_start  (go_start),
        .go_stop   (go_stop),
        .fast_mode (fast_mode),
        .busy      (bus_busy)
    );

    // Bit counter: cleared as a START ends, else stepped by byte clocking.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_cnt <= '0;
        else if (start_fin) bit_cnt <= '0;
        else if (bit_step)  bit_cnt <= bit_cnt + 1'b1;
    end

    // R7
    bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_go |-> (bit_cnt == '0));

    // R1
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !seq_active) |=> !seq_active);

endmodule

// File: tb/bus_cond_gen_tb_top.sv
// Bench: behavioural per-edge model compared on every clock, plus
// scenario checks that measure the intervals directly.
module bus_cond_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_en = 1'b0, fast_mode = 1'b0, wr_stb = 1'b0;
    logic wr_master = 1'b0, wr_xmit = 1'b0, wr_busy = 1'b0, bit_step = 1'b0;
    logic sda_oe, scl_oe, bus_busy, byte_go, cond_done;
    logic [2:0] bit_cnt;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bus_cond_gen dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .fast_mode(fast_mode),
        .wr_stb(wr_stb), .wr_master(wr_master), .wr_xmit(wr_xmit),
        .wr_busy(wr_busy), .bit_step(bit_step), .sda_oe(sda_oe),
        .scl_oe(scl_oe), .bus_busy(bus_busy), .bit_cnt(bit_cnt),
        .byte_go(byte_go), .cond_done(cond_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model state.
    int  e_sda = 0, e_scl = 0, e_busy = 0, e_bit = 0, e_done = 0, e_byte = 0;
    int  m_act = 0, m_t = 0, m_su = 0, m_hd = 0, m_start = 0;
    int  b_pend = 0, b_t = 0, b_lim = 0, b_tgt = 0;
    bit  seen_edge = 0;

    always @(posedge clk) begin
        seen_edge = 1;
        if (!rst_n) begin
            e_sda = 0; e_scl = 0; e_busy = 0; e_bit = 0; e_done = 0; e_byte = 0;
            m_act = 0; b_pend = 0;
        end else begin
            e_done = 0; e_byte = 0;
            if (bit_step) e_bit = (e_bit + 1) % 8;
            if (b_pend != 0) begin
                b_t++;
                if (b_t == b_lim) begin e_busy = b_tgt; b_pend = 0; end
            end
            if (m_act != 0) begin
                m_t++;
                if (m_t == m_su) e_sda = m_start;
                if (m_t == m_su + m_hd) begin
                    m_act = 0; e_done = 1;
                    if (m_start != 0) begin e_scl = 1; e_byte = 1; e_bit = 0; end
                end
            end else if (ctl_en && wr_stb && wr_master && wr_xmit) begin
                m_act = 1; m_t = 0; m_start = wr_busy ? 1 : 0;
                m_su = fast_mode ? 7 : 17;
                m_hd = fast_mode ? 10 : 20;
                e_sda = wr_busy ? 0 : 1;
                e_scl = 0;
                b_pend = 1; b_t = 0; b_tgt = m_start;
                b_lim = fast_mode ? 6 : 12;
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (seen_edge) begin
            chk(sda_oe == e_sda[0], "R2 R3 sda_oe", int'(sda_oe), e_sda);
            chk(scl_oe == e_scl[0], "R2 R3 scl_oe", int'(scl_oe), e_scl);
            chk(bus_busy == e_busy[0], "R6 bus_busy", int'(bus_busy), e_busy);
            chk(int'(bit_cnt) == e_bit, "R7 bit_cnt", int'(bit_cnt), e_bit);
            chk(cond_done == e_done[0], "R9 cond_done", int'(cond_done), e_done);
            chk(byte_go == e_byte[0], "R7 byte_go", int'(byte_go), e_byte);
        end
    end

    task automatic do_write(input bit m, input bit x, input bit b);
        @(negedge clk);
        wr_master = m; wr_xmit = x; wr_busy = b; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // Edges after acceptance until SDA moves, busy moves, done rises.
    task automatic measure(output int k_sda, output int k_busy, output int k_done);
        logic s0, b0;
        s0 = sda_oe; b0 = bus_busy;
        k_sda = -1; k_busy = -1; k_done = -1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (k_sda < 0 && sda_oe != s0) k_sda = k;
            if (k_busy < 0 && bus_busy != b0) k_busy = k;
            if (k_done < 0 && cond_done) k_done = k;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ks, kb, kd;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(!sda_oe && !scl_oe && !bus_busy && bit_cnt == 0 && !cond_done,
            "R10 reset", int'({sda_oe, scl_oe, bus_busy, cond_done}), 0);
        rst_n = 1'b1;
        idle(2);

        // R1: disabled write does nothing
        do_write(1, 1, 1);
        idle(45);
        chk(!bus_busy && !sda_oe && !scl_oe, "R1 disabled", int'({bus_busy, sda_oe}), 0);
        ctl_en = 1'b1;

        // R8: malformed writes ignored
        do_write(0, 1, 1);
        idle(45);
        chk(!bus_busy && !sda_oe, "R8 master=0", int'({bus_busy, sda_oe}), 0);
        do_write(1, 0, 1);
        idle(45);
        chk(!bus_busy && !sda_oe, "R8 xmit=0", int'({bus_busy, sda_oe}), 0);

        // R4 R6: standard START
        do_write(1, 1, 1);
        measure(ks, kb, kd);
        chk(ks == 17, "R4 start setup", ks, 17);
        chk(kd == 37, "R4 start end", kd, 37);
        chk(kb == 12, "R6 busy set std", kb, 12);
        chk(sda_oe && scl_oe && bit_cnt == 0, "R2 after start", int'({sda_oe, scl_oe}), 3);

        // R7: counter stepping and wrap
        @(negedge clk); bit_step = 1'b1;
        repeat (3) @(negedge clk);
        bit_step = 1'b0;
        chk(bit_cnt == 3, "R7 step", int'(bit_cnt), 3);
        bit_step = 1'b1;
        repeat (5) @(negedge clk);
        bit_step = 1'b0;
        chk(bit_cnt == 0, "R7 wrap", int'(bit_cnt), 0);

        // R3 R4 R6: standard STOP
        do_write(1, 1, 0);
        measure(ks, kb, kd);
        chk(ks == 17, "R3 stop setup", ks, 17);
        chk(kd == 37, "R4 stop end", kd, 37);
        chk(kb == 12, "R6 busy clear std", kb, 12);
        chk(!sda_oe && !scl_oe, "R3 after stop", int'({sda_oe, scl_oe}), 0);

        // R5: high-speed START, mode flipped mid-condition
        fast_mode = 1'b1;
        do_write(1, 1, 1);
        fast_mode = 1'b0;
        measure(ks, kb, kd);
        chk(ks == 7, "R5 start setup", ks, 7);
        chk(kd == 17, "R5 start end", kd, 17);
        chk(kb == 6, "R6 busy set fast", kb, 6);

        // R8: STOP written during a running START is ignored
        do_write(1, 1, 1);
        idle(4);
        do_write(1, 1, 0);
        idle(60);
        chk(bus_busy && sda_oe && scl_oe, "R8 late stop", int'({bus_busy, sda_oe, scl_oe}), 7);

        // R5 R6: high-speed STOP
        fast_mode = 1'b1;
        do_write(1, 1, 0);
        measure(ks, kb, kd);
        chk(ks == 7, "R5 stop setup", ks, 7);
        chk(kd == 17, "R5 stop end", kd, 17);
        chk(kb == 6, "R6 busy clear fast", kb, 6);
        chk(!bus_busy, "R6 idle", int'(bus_busy), 0);

        // R10: reset mid-START
        fast_mode = 1'b0;
        do_write(1, 1, 1);
        idle(20);
        rst_n = 1'b0;
        idle(2);
        chk(!sda_oe && !scl_oe && !bus_busy && !cond_done, "R10 mid reset",
            int'({sda_oe, scl_oe, bus_busy}), 0);
        rst_n = 1'b1;
        idle(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule